// File: doc/BRIEF.md
# Flash Program/Erase Sequencing Interlock

This block sits between a simple request/ready bus and an on-chip non-volatile array. It guards the sequence that leads up to a high-voltage program or erase step. A control register holds three bits: a setup bit that opens a program/erase session, an erase-mode bit, and a high-voltage enable bit. While a session is open, array writes do not reach the array. In program mode they fill a set of page buffers. In erase mode any array write serves as the erase interlock write. The high-voltage bit is accepted only once such a qualifying write has been seen in the current session.

The array is modelled as a plain word memory that resets to the erased value, all ones. The high-voltage step is modelled at the moment software clears the high-voltage bit. In program mode the valid page-buffer entries are written into the array. In erase mode the whole block named by the interlock write is set to all ones. When software closes the session, the block releases the buffers and the arming state. It then stalls array reads for a fixed recovery window.

Address bit `ADDR_W-1` set selects the control register, and clear selects the array. An array word address is laid out as {block, page, low}. With the defaults this is 1 block bit, 3 page bits and 2 low bits, which gives 64 words of 16 bits.

Top module: `flash_pe_guard`

## Requirements
- R1: After reset the control register reads 0, `hv_en_o` is 0, every array word reads 16'hFFFF, and array reads complete with no stall.
- R2: A register write that sets the high-voltage bit (bit 2) takes effect only if setup was already 1 before that write, the write keeps setup at 1 and leaves the erase bit unchanged, and a programming write or erase interlock write has been accepted since setup was last set. Otherwise the bit stays 0.
- R3: A single register write that clears setup and sets the high-voltage bit leaves the high-voltage bit at 0. The high-voltage bit is never 1 while setup is 0.
- R4: While the high-voltage bit is 1, register writes cannot change setup (bit 0) or erase (bit 1). Only the high-voltage bit follows the written value.
- R5: The first programming write of a session (setup=1, erase=0) latches its page field. All later programming writes in the session use that page, whatever their own page bits are.
- R6: Each programming write stores its data in the buffer entry selected by {block, low} of its address. A later write to the same entry overwrites the earlier one.
- R7: Array writes made while the high-voltage bit is 1 change neither the buffers nor the array.
- R8: With setup=1 and erase=1, any array write arms the session and records its block. Clearing the high-voltage bit then sets every word of that block to 16'hFFFF and leaves the other blocks unchanged.
- R9: The array contents change only on the write that clears the high-voltage bit. In program mode that write stores each valid buffer entry at {its block, latched page, its low bits}.
- R10: A register write that changes setup or erase while the high-voltage bit is 0 empties the page buffers, drops the page latch and clears the arming state. A fresh session needs a new qualifying write before the high-voltage bit can be set.
- R11: After setup is cleared, an array read issued on the next cycle sees `ready_o` low for RECOV_CYC (16) cycles and then completes with correct data.
- R12: Array writes while setup is 0 complete at once and leave the array unchanged.
- R13: Changing the erase bit inside an open session clears the arming state. A write that changes erase and sets the high-voltage bit together is rejected.
- R14: A register read returns setup in bit 0, erase in bit 1, the high-voltage bit in bit 2 and zeros above. Array reads during a session return the current array contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus request, held until `ready_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | MSB set = control register, clear = array word address |
| wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Access completes at the next clock edge |
| rdata_o | output | DATA_W | Read data, valid while `ready_o` is high on a read |
| hv_en_o | output | 1 | High-voltage enable to the array |

## Verification
The assertions assume a single bus master that holds a request stable until `ready_o`, so register writes and array writes never occur in the same cycle. They also assume that software clears the high-voltage bit before it closes a session. The stimulus drives one transfer at a time from tasks that wait for `ready_o`, and it always drops the high-voltage bit in its own write before clearing setup. Illegal orderings such as the combined clear-setup/set-high-voltage write are issued only as single register writes, whose outcome the requirements define.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  localparam int unsigned CTL_W = 3;

  typedef struct packed {
    logic hv;
    logic erase;
    logic setup;
  } ctl_t;
endpackage

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int unsigned RECOV_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reg_wr_i,
  input  ctl_t wr_ctl_i,
  input  logic arr_wr_i,
  output ctl_t ctl_o,
  output logic prog_wr_o,
  output logic ilk_wr_o,
  output logic buf_clr_o,
  output logic commit_pgm_o,
  output logic commit_ers_o,
  output logic recov_busy_o
);
  localparam int unsigned RC_W = $clog2(RECOV_CYC + 1);

  ctl_t ctl_q, ctl_d;
  logic armed_q, armed_d;
  logic rec_load;
  logic commit;
  logic [RC_W-1:0] rec_q;

  assign prog_wr_o = arr_wr_i & ctl_q.setup & ~ctl_q.erase & ~ctl_q.hv;
  assign ilk_wr_o  = arr_wr_i & ctl_q.setup &  ctl_q.erase & ~ctl_q.hv;

  always_comb begin
    ctl_d     = ctl_q;
    armed_d   = armed_q;
    buf_clr_o = 1'b0;
    rec_load  = 1'b0;
    if (reg_wr_i) begin
      if (ctl_q.hv) begin
        // session bits frozen while high voltage is on
        ctl_d.hv = wr_ctl_i.hv;
      end else begin
        ctl_d.setup = wr_ctl_i.setup;
        ctl_d.erase = wr_ctl_i.erase;
        ctl_d.hv    = wr_ctl_i.hv & ctl_q.setup & wr_ctl_i.setup &
                      (wr_ctl_i.erase == ctl_q.erase) & armed_q;
        if ((wr_ctl_i.setup != ctl_q.setup) || (wr_ctl_i.erase != ctl_q.erase)) begin
          armed_d   = 1'b0;
          buf_clr_o = 1'b1;
        end
        rec_load = ctl_q.setup & ~wr_ctl_i.setup;
      end
    end else if (prog_wr_o || ilk_wr_o) begin
      armed_d = 1'b1;
    end
  end

  assign commit       = ctl_q.hv & ~ctl_d.hv;
  assign commit_pgm_o = commit & ~ctl_q.erase;
  assign commit_ers_o = commit &  ctl_q.erase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rec_q <= '0;
    else if (rec_load)        rec_q <= RC_W'(RECOV_CYC);
    else if (rec_q != '0)     rec_q <= rec_q - 1'b1;
  end

  assign recov_busy_o = (rec_q != '0);
  assign ctl_o        = ctl_q;

  a_r2_hv_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_q.hv) |-> ($past(ctl_q.setup) && $past(armed_q)));

  a_r3_hv_implies_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.hv |-> ctl_q.setup);

  a_r4_session_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.hv |=> ($stable(ctl_q.setup) && $stable(ctl_q.erase)));

  a_r11_recov_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctl_q.setup) |-> recov_busy_o);

  a_r10_arm_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_clr_o |=> !armed_q);
endmodule

// File: rtl/flash_pe_pagebuf.sv
module flash_pe_pagebuf #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BLK_W  = 1,
  parameter int unsigned PG_W   = 3,
  parameter int unsigned LOW_W  = 2,
  localparam int unsigned ARR_AW = BLK_W + PG_W + LOW_W,
  localparam int unsigned IDX_W  = BLK_W + LOW_W,
  localparam int unsigned NB     = 1 << IDX_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       prog_wr_i,
  input  logic                       ilk_wr_i,
  input  logic                       hv_i,
  input  logic [ARR_AW-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [NB-1:0][DATA_W-1:0]  data_o,
  output logic [NB-1:0]              valid_o,
  output logic [PG_W-1:0]            pg_off_o,
  output logic [BLK_W-1:0]           ers_blk_o
);
  logic [NB-1:0][DATA_W-1:0] data_q;
  logic [NB-1:0]             valid_q;
  logic [PG_W-1:0]           pg_off_q;
  logic                      pg_lat_q;
  logic [BLK_W-1:0]          ers_blk_q;
  logic [IDX_W-1:0]          idx;
  logic [BLK_W-1:0]          blk;
  logic [PG_W-1:0]           page;

  assign blk  = addr_i[ARR_AW-1 -: BLK_W];
  assign page = addr_i[LOW_W +: PG_W];
  assign idx  = {blk, addr_i[LOW_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= '0;
    end else if (clr_i) begin
      valid_q <= '0;
    end else if (prog_wr_i) begin
      data_q[idx]  <= wdata_i;
      valid_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_off_q <= '0;
      pg_lat_q <= 1'b0;
    end else if (clr_i) begin
      pg_lat_q <= 1'b0;
    end else if (prog_wr_i && !pg_lat_q) begin
      pg_off_q <= page;
      pg_lat_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ers_blk_q <= '0;
    else if (ilk_wr_i) ers_blk_q <= blk;
  end

  assign data_o    = data_q;
  assign valid_o   = valid_q;
  assign pg_off_o  = pg_off_q;
  assign ers_blk_o = ers_blk_q;

  a_r7_buf_frozen_hv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_i |=> ($stable(valid_q) && $stable(data_q)));

  a_r5_page_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg_lat_q && !clr_i) |=> $stable(pg_off_q));
endmodule

// File: rtl/flash_pe_array.sv
module flash_pe_array #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BLK_W  = 1,
  parameter int unsigned PG_W   = 3,
  parameter int unsigned LOW_W  = 2,
  localparam int unsigned ARR_AW = BLK_W + PG_W + LOW_W,
  localparam int unsigned NWORDS = 1 << ARR_AW,
  localparam int unsigned IDX_W  = BLK_W + LOW_W,
  localparam int unsigned NB     = 1 << IDX_W,
  localparam int unsigned BLK_SH = PG_W + LOW_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      commit_pgm_i,
  input  logic                      commit_ers_i,
  input  logic [NB-1:0][DATA_W-1:0] buf_data_i,
  input  logic [NB-1:0]             buf_valid_i,
  input  logic [PG_W-1:0]           pg_off_i,
  input  logic [BLK_W-1:0]          ers_blk_i,
  input  logic [ARR_AW-1:0]         rd_addr_i,
  output logic [DATA_W-1:0]         rdata_o
);
  logic [NWORDS-1:0][DATA_W-1:0] mem_q;
  logic [NB-1:0][ARR_AW-1:0]     pgm_addr;
  logic [NWORDS-1:0]             in_ers_blk;

  for (genvar g = 0; g < NB; g++) begin : g_pgm_addr
    assign pgm_addr[g] = {BLK_W'(g >> LOW_W), pg_off_i, LOW_W'(g)};
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_ers_sel
    assign in_ers_blk[w] = (BLK_W'(w >> BLK_SH) == ers_blk_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '1;
    end else if (commit_pgm_i) begin
      for (int i = 0; i < NB; i++)
        if (buf_valid_i[i]) mem_q[pgm_addr[i]] <= buf_data_i[i];
    end else if (commit_ers_i) begin
      for (int w = 0; w < NWORDS; w++)
        if (in_ers_blk[w]) mem_q[w] <= '1;
    end
  end

  assign rdata_o = mem_q[rd_addr_i];

  a_r9_mem_only_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_pgm_i && !commit_ers_i) |=> $stable(mem_q));
endmodule

// File: rtl/flash_pe_guard.sv
module flash_pe_guard
  import flash_pe_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BLK_W     = 1,
  parameter int unsigned PG_W      = 3,
  parameter int unsigned LOW_W     = 2,
  parameter int unsigned RECOV_CYC = 16,
  localparam int unsigned ARR_AW   = BLK_W + PG_W + LOW_W,
  localparam int unsigned ADDR_W   = ARR_AW + 1,
  localparam int unsigned NB       = 1 << (BLK_W + LOW_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              hv_en_o
);
  logic                      is_reg;
  logic                      reg_wr, arr_wr;
  ctl_t                      ctl, wr_ctl;
  logic                      prog_wr, ilk_wr, buf_clr;
  logic                      commit_pgm, commit_ers, recov_busy;
  logic [NB-1:0][DATA_W-1:0] buf_data;
  logic [NB-1:0]             buf_valid;
  logic [PG_W-1:0]           pg_off;
  logic [BLK_W-1:0]          ers_blk;
  logic [DATA_W-1:0]         arr_rdata;

  assign is_reg  = addr_i[ADDR_W-1];
  assign reg_wr  = req_i & we_i &  is_reg;
  assign arr_wr  = req_i & we_i & ~is_reg;
  assign wr_ctl  = ctl_t'(wdata_i[CTL_W-1:0]);
  assign ready_o = ~(req_i & ~we_i & ~is_reg & recov_busy);
  assign rdata_o = is_reg ? {{(DATA_W-CTL_W){1'b0}}, ctl} : arr_rdata;
  assign hv_en_o = ctl.hv;

  flash_pe_ctrl #(.RECOV_CYC(RECOV_CYC)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_wr_i     (reg_wr),
    .wr_ctl_i     (wr_ctl),
    .arr_wr_i     (arr_wr),
    .ctl_o        (ctl),
    .prog_wr_o    (prog_wr),
    .ilk_wr_o     (ilk_wr),
    .buf_clr_o    (buf_clr),
    .commit_pgm_o (commit_pgm),
    .commit_ers_o (commit_ers),
    .recov_busy_o (recov_busy)
  );

  flash_pe_pagebuf #(.DATA_W(DATA_W), .BLK_W(BLK_W), .PG_W(PG_W), .LOW_W(LOW_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (buf_clr),
    .prog_wr_i (prog_wr),
    .ilk_wr_i  (ilk_wr),
    .hv_i      (ctl.hv),
    .addr_i    (addr_i[ARR_AW-1:0]),
    .wdata_i   (wdata_i),
    .data_o    (buf_data),
    .valid_o   (buf_valid),
    .pg_off_o  (pg_off),
    .ers_blk_o (ers_blk)
  );

  flash_pe_array #(.DATA_W(DATA_W), .BLK_W(BLK_W), .PG_W(PG_W), .LOW_W(LOW_W)) u_arr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_pgm_i (commit_pgm),
    .commit_ers_i (commit_ers),
    .buf_data_i   (buf_data),
    .buf_valid_i  (buf_valid),
    .pg_off_i     (pg_off),
    .ers_blk_i    (ers_blk),
    .rd_addr_i    (addr_i[ARR_AW-1:0]),
    .rdata_o      (arr_rdata)
  );

  a_r12_idle_write_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_wr && !ctl.setup) |-> (!prog_wr && !ilk_wr));
endmodule

// File: tb/tb_flash_pe_guard.sv
module tb_flash_pe_guard;
  localparam int PERIOD = 10;
  localparam int REG_A  = 'h40;

  logic        clk = 1'b0, rst_ni = 1'b0, req = 1'b0, we = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        ready, hv;
  logic [15:0] rdata;

  flash_pe_guard dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata), .hv_en_o(hv)
  );

  always #(PERIOD/2) clk = ~clk;

  int    n_chk = 0, n_fail = 0;
  string cur = "R1";

  // reference model state
  bit m_ses, m_ers, m_hv, m_arm, m_pgl;
  int m_rec, m_pg, m_eblk;
  int mem[64];
  int bd[8];
  bit bv[8];

  function automatic void check(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endfunction

  function automatic bit exp_ready();
    return !(req && !we && !addr[6] && m_rec > 0);
  endfunction

  function automatic void commit();
    if (!m_ers) begin
      for (int i = 0; i < 8; i++)
        if (bv[i]) mem[(i / 4) * 32 + m_pg * 4 + (i % 4)] = bd[i];
    end else begin
      for (int w = 0; w < 64; w++)
        if (w / 32 == m_eblk) mem[w] = 'hFFFF;
    end
  endfunction

  function automatic void step();
    bit rdy = exp_ready();
    bit load = 0;
    if (req && rdy && we && addr[6]) begin
      bit w_ses = wdata[0], w_ers = wdata[1], w_hv = wdata[2];
      if (m_hv) begin
        if (!w_hv) commit();
        m_hv = w_hv;
      end else begin
        bit nhv = w_hv && m_ses && w_ses && (w_ers == m_ers) && m_arm;
        if (m_ses && !w_ses) load = 1;
        if (w_ses != m_ses || w_ers != m_ers) begin
          m_arm = 0; m_pgl = 0;
          for (int i = 0; i < 8; i++) bv[i] = 0;
        end
        m_ses = w_ses; m_ers = w_ers; m_hv = nhv;
      end
    end else if (req && we && !addr[6] && m_ses && !m_hv) begin
      if (!m_ers) begin
        int idx = int'(addr[5]) * 4 + int'(addr[1:0]);
        bd[idx] = wdata; bv[idx] = 1;
        if (!m_pgl) begin m_pg = int'(addr[4:2]); m_pgl = 1; end
      end else begin
        m_eblk = int'(addr[5]);
      end
      m_arm = 1;
    end
    if (load) m_rec = 16;
    else if (m_rec > 0) m_rec--;
  endfunction

  always @(posedge clk) if (rst_ni) step();

  task automatic compare_now();
    check(cur, int'(ready), int'(exp_ready()), "ready");
    check(cur, int'(hv), int'(m_hv), "hv_en");
    if (req && !we && ready)
      check(cur, int'(rdata), addr[6] ? int'({m_hv, m_ers, m_ses}) : mem[addr[5:0]], "rdata");
  endtask

  task automatic xfer(bit w, int a, int d, output int rd, output int stalls);
    stalls = 0;
    @(negedge clk);
    req = 1'b1; we = w; addr = a[6:0]; wdata = d[15:0];
    forever begin
      #(PERIOD/4);
      compare_now();
      if (ready) begin rd = int'(rdata); break; end
      stalls++;
      @(negedge clk);
    end
  endtask

  task automatic wr(int a, int d);
    int r, s;
    xfer(1'b1, a, d, r, s);
  endtask

  task automatic rd_chk(string tag, int a, int exp);
    int r, s;
    cur = tag;
    xfer(1'b0, a, 0, r, s);
    check(tag, r, exp, "read");
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      req = 1'b0; we = 1'b0;
      #(PERIOD/4);
      compare_now();
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(PERIOD * 50000);
    n_fail++;
    $display("FAIL all watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int r, s;
    for (int w = 0; w < 64; w++) mem[w] = 'hFFFF;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd_chk("R1", REG_A, 0);
    rd_chk("R1", 'h00, 'hFFFF);
    check("R1", int'(hv), 0, "hv_en");

    // R12 direct write with no session
    cur = "R12"; wr('h05, 'h1234);
    rd_chk("R12", 'h05, 'hFFFF);

    // R2 setup then premature high voltage
    cur = "R2"; wr(REG_A, 'h1); wr(REG_A, 'h5);
    rd_chk("R2", REG_A, 'h1);

    // R5/R6 programming writes
    cur = "R5"; wr('h0D, 'hA001);
    cur = "R6"; wr('h36, 'hB002); wr('h01, 'hA003);
    rd_chk("R9", 'h0D, 'hFFFF);
    cur = "R2"; wr(REG_A, 'h5);
    rd_chk("R14", REG_A, 'h5);
    check("R2", int'(hv), 1, "hv_en");
    cur = "R4"; wr(REG_A, 'h7);
    rd_chk("R4", REG_A, 'h5);
    cur = "R7"; wr('h0F, 'hDEAD);
    cur = "R9"; wr(REG_A, 'h1);
    rd_chk("R5", 'h0D, 'hA003);
    rd_chk("R6", 'h2E, 'hB002);
    rd_chk("R7", 'h0F, 'hFFFF);
    rd_chk("R5", 'h36, 'hFFFF);

    // R11 recovery stall after release
    cur = "R11"; wr(REG_A, 'h0);
    xfer(1'b0, 'h0D, 0, r, s);
    check("R11", s, 16, "stall_cycles");
    check("R11", r, 'hA003, "read");

    // R10 fresh session needs a new write, old buffers gone
    cur = "R10"; wr(REG_A, 'h1); wr(REG_A, 'h5);
    rd_chk("R10", REG_A, 'h1);
    cur = "R10"; wr('h10, 'hC0C0); wr(REG_A, 'h5); wr(REG_A, 'h1);
    rd_chk("R10", 'h10, 'hC0C0);
    rd_chk("R10", 'h11, 'hFFFF);
    rd_chk("R10", 'h32, 'hFFFF);
    cur = "R10"; wr(REG_A, 'h0); idle(20);

    // R13 erase change inside session
    cur = "R13"; wr(REG_A, 'h1); wr('h00, 'h1111); wr(REG_A, 'h7);
    rd_chk("R13", REG_A, 'h3);
    cur = "R13"; wr(REG_A, 'h7);
    rd_chk("R13", REG_A, 'h3);

    // R8 erase of one block; R14 reads during a session
    rd_chk("R14", 'h0D, 'hA003);
    cur = "R8"; wr('h25, 'h0); wr(REG_A, 'h7);
    rd_chk("R8", REG_A, 'h7);
    cur = "R8"; wr(REG_A, 'h3);
    rd_chk("R8", 'h2E, 'hFFFF);
    rd_chk("R8", 'h0D, 'hA003);
    rd_chk("R8", 'h10, 'hC0C0);

    // R3 combined clear-setup / set-high-voltage
    cur = "R3"; wr(REG_A, 'h6);
    rd_chk("R3", REG_A, 'h2);
    check("R3", int'(hv), 0, "hv_en");
    idle(20);

    summary();
    $finish;
  end
endmodule